// File: doc/BRIEF.md
# Ethernet PHY Control Register

This block holds the 16-bit management control word of an Ethernet PHY. Software reads it and writes it through a simple register-bus port: a write strobe with write data, and a read-data output that always shows the current word. Each stored field drives one control output to the rest of the PHY. These outputs cover the speed choice, duplex, collision test, auto-negotiation enable, the auto-negotiation restart command, power down, isolate, loopback and a soft-reset request.

Two fields are commands that clear themselves through a handshake with the PHY logic. The soft-reset request stays raised until the PHY returns a reset-done pulse. That pulse reloads the whole word with its default value. The auto-negotiation restart raises a one-cycle pulse toward the negotiation engine, and its bit falls once the engine acknowledges.

The same word also gates a transmit/receive data path of parameterised width. Loopback turns transmit data back into the receive side. Power down and isolate force the path to idle.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After the synchronous reset the word reads 0x3100. The speed, auto-negotiation enable and duplex outputs are 1, and every other control output and the restart pulse are 0.
- R2: Bits 15 down to 7 take the written value at the clock edge where the write strobe is sampled. Bits 6 down to 0 always read 0, whatever is written to them.
- R3: The outputs follow the fields as follows: bit 15 drives the soft-reset request, 14 loopback, 13 speed (1 = 100 Mb/s, 0 = 10 Mb/s), 12 auto-negotiation enable, 11 power down, 10 isolate, 9 restart pending, 8 full duplex and 7 collision test.
- R4: A write with bit 9 set raises the restart pulse for exactly the one cycle after the write, while bit 9 reads 1. Bit 9 then stays 1 until the acknowledge input is sampled high, and it reads 0 from the next cycle on.
- R5: A write with bit 15 set holds the soft-reset request high until the reset-done input is sampled high. At that edge the whole word, bit 15 included, reloads to 0x3100.
- R6: Reset-done has no effect while bit 15 is 0, and the acknowledge input has no effect while bit 9 is 0.
- R7: A write in the same cycle as an effective reset-done or acknowledge wins, and the word takes the written value.
- R8: With loopback set and neither power down nor isolate set, receive output data and valid equal the transmit input data and valid, and the line transmit outputs are idle (all zero).
- R9: With loopback, power down and isolate all clear, the line transmit outputs carry the transmit input and the receive outputs carry the line receive input.
- R10: With power down or isolate set, the line transmit outputs and the receive outputs are all zero, whatever the loopback setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register word |
| rst_done | input | 1 | Soft reset completed pulse from PHY logic |
| aneg_ack | input | 1 | Auto-negotiation restart acknowledge |
| ctl_soft_rst_req | output | 1 | Soft reset request, held until done |
| ctl_loopback | output | 1 | Loopback enabled |
| ctl_speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ctl_aneg_en | output | 1 | Auto-negotiation enabled |
| ctl_power_down | output | 1 | Low-power state |
| ctl_isolate | output | 1 | Data path isolated |
| ctl_aneg_restart | output | 1 | One-cycle restart pulse |
| ctl_full_duplex | output | 1 | Full duplex selected |
| ctl_col_test | output | 1 | Collision test enabled |
| tx_in_data | input | DATA_W | Transmit data from the MAC side |
| tx_in_valid | input | 1 | Transmit data valid |
| tx_line_data | output | DATA_W | Transmit data toward the line |
| tx_line_valid | output | 1 | Line transmit valid |
| rx_line_data | input | DATA_W | Receive data from the line |
| rx_line_valid | input | 1 | Line receive valid |
| rx_out_data | output | DATA_W | Receive data toward the MAC side |
| rx_out_valid | output | 1 | Receive data valid |

## Verification
The bench builds the block with the default DATA_W of 4, the width of a nibble-wide media interface. At that width all sixteen data values can be sent through the loopback, normal and idle paths in short loops. The directed scenarios cover the edge cases of the handshakes: an acknowledge or reset-done that arrives while its bit is clear, a write that lands in the same cycle as a self-clear, and a soft-reset request held across several idle cycles before the done pulse.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned FIELD_W = 9;
    localparam int unsigned RSVD_W  = WORD_W - FIELD_W;
    localparam logic [WORD_W-1:0] WORD_DEFAULT = 16'h3100;

    // Field order follows the bit order of the word, bit 15 first.
    typedef struct packed {
        logic soft_rst;
        logic loopback;
        logic speed_100;
        logic aneg_en;
        logic power_down;
        logic isolate;
        logic aneg_restart;
        logic full_duplex;
        logic col_test;
    } ctl_t;

    function automatic ctl_t fields_of(input logic [FIELD_W-1:0] hi);
        fields_of = ctl_t'(hi);
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input ctl_t c);
        word_of = {c, {RSVD_W{1'b0}}};
    endfunction

    localparam ctl_t CTL_DEFAULT = ctl_t'(WORD_DEFAULT[WORD_W-1:RSVD_W]);

endpackage

// File: rtl/phyctl_fields.sv
module phyctl_fields
    import phyctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_hi,
    input  logic               done_in,
    input  logic               ack_in,
    output ctl_t               ctl_q,
    output logic               restart_pulse
);

    ctl_t ctl_nxt;

    always_comb begin
        ctl_nxt = ctl_q;
        if (done_in && ctl_q.soft_rst) begin
            ctl_nxt = CTL_DEFAULT;
        end
        if (ack_in && ctl_q.aneg_restart) begin
            ctl_nxt.aneg_restart = 1'b0;
        end
        if (wr_en) begin
            ctl_nxt = fields_of(wr_hi);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q         <= CTL_DEFAULT;
            restart_pulse <= 1'b0;
        end else begin
            ctl_q         <= ctl_nxt;
            restart_pulse <= wr_en && fields_of(wr_hi).aneg_restart;
        end
    end

endmodule

// File: rtl/phyctl_gate.sv
module phyctl_gate #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              loopback,
    input  logic              power_down,
    input  logic              isolate,
    input  logic [DATA_W-1:0] tx_in_data,
    input  logic              tx_in_valid,
    input  logic [DATA_W-1:0] rx_line_data,
    input  logic              rx_line_valid,
    output logic [DATA_W-1:0] tx_line_data,
    output logic              tx_line_valid,
    output logic [DATA_W-1:0] rx_out_data,
    output logic              rx_out_valid
);

    logic idle;
    assign idle = power_down || isolate;

    always_comb begin
        if (idle) begin
            tx_line_data  = '0;
            tx_line_valid = 1'b0;
            rx_out_data   = '0;
            rx_out_valid  = 1'b0;
        end else if (loopback) begin
            tx_line_data  = '0;
            tx_line_valid = 1'b0;
            rx_out_data   = tx_in_data;
            rx_out_valid  = tx_in_valid;
        end else begin
            tx_line_data  = tx_in_data;
            tx_line_valid = tx_in_valid;
            rx_out_data   = rx_line_data;
            rx_out_valid  = rx_line_valid;
        end
    end

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phyctl_pkg::*;
#(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rst_done,
    input  logic              aneg_ack,
    output logic              ctl_soft_rst_req,
    output logic              ctl_loopback,
    output logic              ctl_speed_100,
    output logic              ctl_aneg_en,
    output logic              ctl_power_down,
    output logic              ctl_isolate,
    output logic              ctl_aneg_restart,
    output logic              ctl_full_duplex,
    output logic              ctl_col_test,
    input  logic [DATA_W-1:0] tx_in_data,
    input  logic              tx_in_valid,
    output logic [DATA_W-1:0] tx_line_data,
    output logic              tx_line_valid,
    input  logic [DATA_W-1:0] rx_line_data,
    input  logic              rx_line_valid,
    output logic [DATA_W-1:0] rx_out_data,
    output logic              rx_out_valid
);

    ctl_t ctl;
    logic unused_wr_lo;

    assign unused_wr_lo = ^reg_wdata[RSVD_W-1:0];

    phyctl_fields u_fields (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (reg_wr),
        .wr_hi         (reg_wdata[WORD_W-1:RSVD_W]),
        .done_in       (rst_done),
        .ack_in        (aneg_ack),
        .ctl_q         (ctl),
        .restart_pulse (ctl_aneg_restart)
    );

    assign reg_rdata        = word_of(ctl);
    assign ctl_soft_rst_req = ctl.soft_rst;
    assign ctl_loopback     = ctl.loopback;
    assign ctl_speed_100    = ctl.speed_100;
    assign ctl_aneg_en      = ctl.aneg_en;
    assign ctl_power_down   = ctl.power_down;
    assign ctl_isolate      = ctl.isolate;
    assign ctl_full_duplex  = ctl.full_duplex;
    assign ctl_col_test     = ctl.col_test;

    phyctl_gate #(.DATA_W(DATA_W)) u_gate (
        .loopback      (ctl.loopback),
        .power_down    (ctl.power_down),
        .isolate       (ctl.isolate),
        .tx_in_data    (tx_in_data),
        .tx_in_valid   (tx_in_valid),
        .rx_line_data  (rx_line_data),
        .rx_line_valid (rx_line_valid),
        .tx_line_data  (tx_line_data),
        .tx_line_valid (tx_line_valid),
        .rx_out_data   (rx_out_data),
        .rx_out_valid  (rx_out_valid)
    );

endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              rst_done,
    input logic              aneg_ack,
    input logic              ctl_soft_rst_req,
    input logic              ctl_loopback,
    input logic              ctl_power_down,
    input logic              ctl_isolate,
    input logic              ctl_aneg_restart,
    input logic [DATA_W-1:0] tx_in_data,
    input logic [DATA_W-1:0] tx_line_data,
    input logic [DATA_W-1:0] rx_out_data
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6:0] == 7'd0);

    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata == {$past(reg_wdata[15:7]), 7'd0});

    p_pulse_with_bit_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_aneg_restart |-> reg_rdata[9]);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (aneg_ack && reg_rdata[9] && !reg_wr) |=> !reg_rdata[9]);

    p_req_held_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_soft_rst_req && !rst_done && !reg_wr) |=> ctl_soft_rst_req);

    p_done_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (rst_done && ctl_soft_rst_req && !reg_wr) |=> reg_rdata == 16'h3100);

    p_loop_path_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_loopback && !ctl_power_down && !ctl_isolate) |->
            (rx_out_data == tx_in_data && tx_line_data == '0));

    p_idle_path_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_power_down || ctl_isolate) |->
            (rx_out_data == '0 && tx_line_data == '0));

endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .reg_wr           (reg_wr),
    .reg_wdata        (reg_wdata),
    .reg_rdata        (reg_rdata),
    .rst_done         (rst_done),
    .aneg_ack         (aneg_ack),
    .ctl_soft_rst_req (ctl_soft_rst_req),
    .ctl_loopback     (ctl_loopback),
    .ctl_power_down   (ctl_power_down),
    .ctl_isolate      (ctl_isolate),
    .ctl_aneg_restart (ctl_aneg_restart),
    .tx_in_data       (tx_in_data),
    .tx_line_data     (tx_line_data),
    .rx_out_data      (rx_out_data)
);

// File: tb/phy_ctrl_reg_bench.sv
module phy_ctrl_reg_bench;

    localparam int unsigned DATA_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              rst_done = 1'b0;
    logic              aneg_ack = 1'b0;
    logic              ctl_soft_rst_req, ctl_loopback, ctl_speed_100, ctl_aneg_en;
    logic              ctl_power_down, ctl_isolate, ctl_aneg_restart;
    logic              ctl_full_duplex, ctl_col_test;
    logic [DATA_W-1:0] tx_in_data = '0;
    logic              tx_in_valid = 1'b0;
    logic [DATA_W-1:0] tx_line_data;
    logic              tx_line_valid;
    logic [DATA_W-1:0] rx_line_data = '0;
    logic              rx_line_valid = 1'b0;
    logic [DATA_W-1:0] rx_out_data;
    logic              rx_out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    phy_ctrl_reg #(.DATA_W(DATA_W)) u_phy_ctrl_reg (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rst_done(rst_done), .aneg_ack(aneg_ack),
        .ctl_soft_rst_req(ctl_soft_rst_req), .ctl_loopback(ctl_loopback),
        .ctl_speed_100(ctl_speed_100), .ctl_aneg_en(ctl_aneg_en),
        .ctl_power_down(ctl_power_down), .ctl_isolate(ctl_isolate),
        .ctl_aneg_restart(ctl_aneg_restart), .ctl_full_duplex(ctl_full_duplex),
        .ctl_col_test(ctl_col_test), .tx_in_data(tx_in_data),
        .tx_in_valid(tx_in_valid), .tx_line_data(tx_line_data),
        .tx_line_valid(tx_line_valid), .rx_line_data(rx_line_data),
        .rx_line_valid(rx_line_valid), .rx_out_data(rx_out_data),
        .rx_out_valid(rx_out_valid)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Write strobe for one cycle; returns at the next falling edge,
    // after the edge that stored the data.
    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        rst_done = 1'b1;
        @(negedge clk);
        rst_done = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        aneg_ack = 1'b1;
        @(negedge clk);
        aneg_ack = 1'b0;
    endtask

    function automatic logic [8:0] outs();
        return {ctl_soft_rst_req, ctl_loopback, ctl_speed_100, ctl_aneg_en,
                ctl_power_down, ctl_isolate, ctl_aneg_restart,
                ctl_full_duplex, ctl_col_test};
    endfunction

    task automatic t_reset();
        chk(reg_rdata, 16'h3100, "R1 reset word");
        chk(outs(), 9'b0_0_1_1_0_0_0_1_0, "R1 reset outputs");
    endtask

    task automatic t_write_mask();
        write_word(16'h4CFF);
        chk(reg_rdata, 16'h4C80, "R2 masked write");
        chk(outs(), 9'b0_1_0_0_1_1_0_0_1, "R3 outputs after 0x4C80");
        write_word(16'h217F);
        chk(reg_rdata, 16'h2100, "R2 reserved bits ignored");
        chk({ctl_speed_100, ctl_full_duplex, ctl_aneg_en}, 3'b110, "R3 speed/duplex map");
    endtask

    task automatic t_restart();
        write_word(16'h1300);
        chk(ctl_aneg_restart, 1'b1, "R4 restart pulse cycle after write");
        chk(reg_rdata, 16'h1300, "R4 bit 9 set");
        @(negedge clk);
        chk(ctl_aneg_restart, 1'b0, "R4 pulse one cycle only");
        repeat (3) @(negedge clk);
        chk(reg_rdata[9], 1'b1, "R4 bit 9 held until ack");
        pulse_ack();
        chk(reg_rdata, 16'h1100, "R4 bit 9 cleared after ack");
    endtask

    task automatic t_ignored();
        pulse_ack();
        chk(reg_rdata, 16'h1100, "R6 ack ignored with bit 9 clear");
        write_word(16'h4100);
        pulse_done();
        chk(reg_rdata, 16'h4100, "R6 done ignored with bit 15 clear");
        chk(ctl_aneg_restart, 1'b0, "R6 no restart pulse");
    endtask

    task automatic t_soft_reset();
        write_word(16'hC580);
        chk(ctl_soft_rst_req, 1'b1, "R5 request raised");
        repeat (4) @(negedge clk);
        chk(ctl_soft_rst_req, 1'b1, "R5 request held");
        chk(reg_rdata, 16'hC580, "R5 word held before done");
        pulse_done();
        chk(reg_rdata, 16'h3100, "R5 reload to default");
        chk(ctl_soft_rst_req, 1'b0, "R5 request cleared");
    endtask

    task automatic t_collide();
        write_word(16'h1300);
        @(negedge clk);
        aneg_ack  = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = 16'h1300;
        @(negedge clk);
        aneg_ack  = 1'b0;
        reg_wr    = 1'b0;
        chk(reg_rdata, 16'h1300, "R7 write beats ack");
        pulse_ack();
        chk(reg_rdata, 16'h1100, "R4 later ack clears");
        write_word(16'h8000);
        @(negedge clk);
        rst_done  = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = 16'h0100;
        @(negedge clk);
        rst_done  = 1'b0;
        reg_wr    = 1'b0;
        chk(reg_rdata, 16'h0100, "R7 write beats reset-done");
    endtask

    task automatic t_datapath();
        write_word(16'h0100);
        for (int i = 0; i < 16; i++) begin
            tx_in_data = DATA_W'(i); tx_in_valid = i[0];
            rx_line_data = DATA_W'(15 - i); rx_line_valid = ~i[0];
            #1;
            chk({tx_line_valid, tx_line_data, rx_out_valid, rx_out_data},
                {i[0], 4'(i), ~i[0], 4'(15 - i)}, "R9 normal path");
        end
        write_word(16'h4100);
        for (int i = 0; i < 16; i++) begin
            tx_in_data = DATA_W'(i); tx_in_valid = 1'b1;
            rx_line_data = DATA_W'(~i); rx_line_valid = 1'b1;
            #1;
            chk({tx_line_valid, tx_line_data, rx_out_valid, rx_out_data},
                {1'b0, 4'd0, 1'b1, 4'(i)}, "R8 loopback path");
        end
        write_word(16'h4900);
        #1;
        chk({tx_line_valid, tx_line_data, rx_out_valid, rx_out_data}, 10'd0,
            "R10 power down over loopback");
        write_word(16'h0500);
        #1;
        chk({tx_line_valid, tx_line_data, rx_out_valid, rx_out_data}, 10'd0,
            "R10 isolate idles path");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_mask();
        t_restart();
        t_ignored();
        t_soft_reset();
        t_collide();
        t_datapath();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule